// File: doc/BRIEF.md
# Parallel Vector Branch Decrement Counter

This block evaluates a whole group of up to N branch-test elements in one step and produces the result that an element-by-element walk in program order would give. From a snapshot of the predicate mask, the condition bit chosen for each element, the active vector length, the branch option bits, the mode bits and the count register value, it returns four things: how many times the count register is decremented, the new count value, the element at which the walk stops early (if any), and whether the branch is taken.

Several branch units can each hold a snapshot and settle a vector branch together, with no sequential access to the condition file. A prefix count of per-element decrements gives every element the count value it would see in a sequential walk. That count value includes the element's own decrement. So a count that reaches zero partway through the vector changes the counter test for the later elements. The inputs are sampled on a rising clock edge, and the outputs are registered, one cycle later.

Top module: `vbr_ctr_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is zero after that edge. Each result appears on the outputs one clock after the inputs it depends on are sampled.
- R2: An element with `pred_mask[i]=1` is tested with `cr_bits[i]`. An element with `pred_mask[i]=0` and `zero_fill=1` is tested with `fill_bit`. An element with `pred_mask[i]=0` and `zero_fill=0` is skipped: it is not tested and cannot stop the walk. An element's condition holds when `ign_cond=1` or when its test bit equals `want_set`.
- R3: When `no_ctr=0`, a tested element counts one decrement in three cases: `ctr_test=0`; `ctr_test=1` with `ctr_inv=0` and the condition holds; `ctr_test=1` with `ctr_inv=1` and the condition does not hold.
- R4: A skipped element counts one decrement only when `no_ctr=0`, `ctr_test=0` and `ctr_inv=1`. Otherwise it counts none.
- R5: When `no_ctr=1`, `dec_count` is 0 and `ctr_out` equals `ctr_in`.
- R6: An element's counter check uses `ctr_in` minus the decrements of all earlier elements and of the element itself. The check passes when `no_ctr=1`, or when (that value is nonzero) XOR `ctr_zero_take`. With `mode32=1`, only bits 31:0 are used for the zero test.
- R7: A tested element passes when both its condition and its counter check hold. With `all_mode=1` the walk stops at the first tested element that fails; with `all_mode=0` it stops at the first tested element that passes. `exit_valid` and `exit_idx` report that element; `exit_idx` is 0 when there is no stop. Elements after the stop count no decrements.
- R8: `take_branch` is `!exit_valid` when `all_mode=1` and `exit_valid` when `all_mode=0`. So with `vl=0` the branch is taken in all-mode and not taken in any-mode.
- R9: Elements with index at or above `vl` are absent and have no effect. Any `vl` of N or more makes all N elements present.
- R10: `ctr_out` equals `ctr_in - dec_count` modulo 2^64, in both 32-bit and 64-bit mode.
- R11: When the walk does not stop, `dec_count` is the number of present elements that count a decrement. When it stops, it is that number for elements up to and including the stop element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_mask | input | N | Predicate bit per element |
| cr_bits | input | N | Selected condition bit per element |
| vl | input | $clog2(N+1) | Active vector length |
| ign_cond | input | 1 | Condition always holds |
| want_set | input | 1 | Test bit value that makes the condition hold |
| no_ctr | input | 1 | Count register untouched and not checked |
| ctr_zero_take | input | 1 | Counter check passes on zero instead of nonzero |
| all_mode | input | 1 | 1: all must pass; 0: first pass wins |
| zero_fill | input | 1 | Masked-out elements are tested with fill_bit |
| fill_bit | input | 1 | Test bit used for masked-out elements |
| ctr_test | input | 1 | Decrement depends on the test outcome |
| ctr_inv | input | 1 | Inverts which outcome decrements |
| mode32 | input | 1 | Zero test looks at bits 31:0 only |
| ctr_in | input | 64 | Count register snapshot |
| dec_count | output | $clog2(N+1) | Number of decrements |
| ctr_out | output | 64 | Updated count register |
| exit_idx | output | $clog2(N) | Element where the walk stopped |
| exit_valid | output | 1 | The walk stopped early |
| take_branch | output | 1 | Branch decision |

## Verification
The embedded properties are checked on every cycle. They cover the zero count under `no_ctr`, the wrap relation between `ctr_in`, `dec_count` and `ctr_out`, the stop index lying below the active length, the branch being taken in all-mode when no stop occurs, and the empty result for `vl=0`. Whether the decrements and the stop point match a sequential walk can only be shown by the bench's behavioural loop, and only for the scenarios it drives. Those scenarios include: a count reaching zero in the middle of the vector, the 32-bit zero test against a value whose upper half is nonzero, the rule for skipped elements, fill-bit testing, and truncation by `vl`.

// File: rtl/vbr_pkg.sv
// Package vbr_pkg
// Shared types for the parallel vector branch counter.
// Assumes: none beyond IEEE 1800-2017.
package vbr_pkg;

    // Branch option bits, grouped
    typedef struct packed {
        logic ign_cond;
        logic want_set;
        logic no_ctr;
        logic zero_take;
    } vbr_opt_t;

    // Vector mode bits, grouped
    typedef struct packed {
        logic all_mode;
        logic zero_fill;
        logic fill_bit;
        logic ctr_test;
        logic ctr_inv;
        logic mode32;
    } vbr_mode_t;

endpackage

// File: rtl/vbr_elem_class.sv
// Module vbr_elem_class
// Classifies every element as absent, skipped or tested. For each one it
// works out the condition outcome and whether it counts a decrement.
// Assumes: N small enough that each index fits in VLW bits.
module vbr_elem_class #(
    parameter int N   = 8,
    parameter int VLW = $clog2(N + 1)
) (
    input  logic [N-1:0]   pred_mask,
    input  logic [N-1:0]   cr_bits,
    input  logic [VLW-1:0] vl,
    input  logic           ign_cond,
    input  logic           want_set,
    input  logic           no_ctr,
    input  logic           zero_fill,
    input  logic           fill_bit,
    input  logic           ctr_test,
    input  logic           ctr_inv,
    output logic [N-1:0]   tested,
    output logic [N-1:0]   cond_ok,
    output logic [N-1:0]   dec
);

    // decrement rule for a masked-out, skipped element
    logic skip_dec;
    assign skip_dec = ~no_ctr & ~ctr_test & ctr_inv;

    for (genvar i = 0; i < N; i++) begin : g_el
        localparam logic [VLW-1:0] IDX = VLW'(i);
        logic present, skipped, tbit, dec_t;

        // presence, role and test bit of element i
        always_comb begin
            present   = (IDX < vl);
            tested[i] = present & (pred_mask[i] | zero_fill);
            skipped   = present & ~pred_mask[i] & ~zero_fill;
            tbit      = pred_mask[i] ? cr_bits[i] : fill_bit;
        end

        // condition outcome and decrement of element i
        always_comb begin
            cond_ok[i] = ign_cond | (tbit == want_set);
            dec_t      = ~no_ctr & (~ctr_test | (ctr_inv ? ~cond_ok[i] : cond_ok[i]));
            dec[i]     = (tested[i] & dec_t) | (skipped & skip_dec);
        end
    end

endmodule

// File: rtl/vbr_prefix_ctr.sv
// Module vbr_prefix_ctr
// Counts decrements up to and including each element. From each count it
// forms the count register value that element sees, and its counter check.
// Assumes: the counter values wrap modulo 2^64.
module vbr_prefix_ctr #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]         dec,
    input  logic [63:0]          ctr_in,
    input  logic                 no_ctr,
    input  logic                 zero_take,
    input  logic                 mode32,
    output logic [N-1:0][CW-1:0] cnt_incl,
    output logic [N-1:0]         ctr_ok
);

    for (genvar i = 0; i < N; i++) begin : g_pf
        logic [63:0] run;
        logic        nz;

        // running decrement count through element i
        if (i == 0) begin : g_first
            assign cnt_incl[i] = CW'(dec[i]);
        end else begin : g_rest
            assign cnt_incl[i] = cnt_incl[i-1] + CW'(dec[i]);
        end

        // counter value seen by element i and its check
        always_comb begin
            run       = ctr_in - 64'(cnt_incl[i]);
            nz        = mode32 ? (|run[31:0]) : (|run);
            ctr_ok[i] = no_ctr | (nz ^ zero_take);
        end
    end

endmodule

// File: rtl/vbr_exit_pick.sv
// Module vbr_exit_pick
// Finds the first tested element that ends the walk and picks the
// decrement count up to that element, or the full count if none ends it.
// Assumes: N >= 1; cnt_incl comes from the prefix counter.
module vbr_exit_pick #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1),
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         tested,
    input  logic [N-1:0]         cond_ok,
    input  logic [N-1:0]         ctr_ok,
    input  logic [N-1:0][CW-1:0] cnt_incl,
    input  logic                 all_mode,
    output logic                 exit_valid,
    output logic [IW-1:0]        exit_idx,
    output logic [CW-1:0]        dec_count
);

    logic [N-1:0] term;

    // element ends the walk when its pass differs from the mode
    assign term = tested & ({N{all_mode}} ^ (cond_ok & ctr_ok));

    // lowest terminating index wins
    always_comb begin
        exit_valid = 1'b0;
        exit_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (!exit_valid && term[i]) begin
                exit_valid = 1'b1;
                exit_idx   = IW'(i);
            end
        end
    end

    // decrements up to the stop point only
    assign dec_count = exit_valid ? cnt_incl[exit_idx] : cnt_incl[N-1];

endmodule

// File: rtl/vbr_ctr_unit.sv
// Module vbr_ctr_unit
// Top of the parallel vector branch counter. Inputs are sampled every
// rising edge and the group result appears one cycle later.
// Assumes: rst_n is synchronous, active low; N >= 2.
module vbr_ctr_unit #(
    parameter int N   = 8,
    parameter int VLW = $clog2(N + 1),
    parameter int CW  = $clog2(N + 1),
    parameter int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   pred_mask,
    input  logic [N-1:0]   cr_bits,
    input  logic [VLW-1:0] vl,
    input  logic           ign_cond,
    input  logic           want_set,
    input  logic           no_ctr,
    input  logic           ctr_zero_take,
    input  logic           all_mode,
    input  logic           zero_fill,
    input  logic           fill_bit,
    input  logic           ctr_test,
    input  logic           ctr_inv,
    input  logic           mode32,
    input  logic [63:0]    ctr_in,
    output logic [CW-1:0]  dec_count,
    output logic [63:0]    ctr_out,
    output logic [IW-1:0]  exit_idx,
    output logic           exit_valid,
    output logic           take_branch
);
    import vbr_pkg::*;

    vbr_opt_t  opt;
    vbr_mode_t mode;

    logic [N-1:0]         tested, cond_ok, dec, ctr_ok;
    logic [N-1:0][CW-1:0] cnt_incl;
    logic                 ev_c;
    logic [IW-1:0]        ei_c;
    logic [CW-1:0]        cnt_c;

    // group the control bits
    assign opt  = '{ign_cond: ign_cond, want_set: want_set,
                    no_ctr: no_ctr, zero_take: ctr_zero_take};
    assign mode = '{all_mode: all_mode, zero_fill: zero_fill, fill_bit: fill_bit,
                    ctr_test: ctr_test, ctr_inv: ctr_inv, mode32: mode32};

    vbr_elem_class #(.N(N), .VLW(VLW)) u_class (
        .pred_mask (pred_mask),
        .cr_bits   (cr_bits),
        .vl        (vl),
        .ign_cond  (opt.ign_cond),
        .want_set  (opt.want_set),
        .no_ctr    (opt.no_ctr),
        .zero_fill (mode.zero_fill),
        .fill_bit  (mode.fill_bit),
        .ctr_test  (mode.ctr_test),
        .ctr_inv   (mode.ctr_inv),
        .tested    (tested),
        .cond_ok   (cond_ok),
        .dec       (dec)
    );

    vbr_prefix_ctr #(.N(N), .CW(CW)) u_prefix (
        .dec       (dec),
        .ctr_in    (ctr_in),
        .no_ctr    (opt.no_ctr),
        .zero_take (opt.zero_take),
        .mode32    (mode.mode32),
        .cnt_incl  (cnt_incl),
        .ctr_ok    (ctr_ok)
    );

    vbr_exit_pick #(.N(N), .CW(CW), .IW(IW)) u_pick (
        .tested     (tested),
        .cond_ok    (cond_ok),
        .ctr_ok     (ctr_ok),
        .cnt_incl   (cnt_incl),
        .all_mode   (mode.all_mode),
        .exit_valid (ev_c),
        .exit_idx   (ei_c),
        .dec_count  (cnt_c)
    );

    // register the group result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_count   <= '0;
            ctr_out     <= '0;
            exit_idx    <= '0;
            exit_valid  <= 1'b0;
            take_branch <= 1'b0;
        end else begin
            dec_count   <= cnt_c;
            ctr_out     <= ctr_in - 64'(cnt_c);
            exit_idx    <= ei_c;
            exit_valid  <= ev_c;
            take_branch <= mode.all_mode ? ~ev_c : ev_c;
        end
    end

    // R5
    no_ctr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(no_ctr) |-> (dec_count == '0) && (ctr_out == $past(ctr_in)));

    // R10
    ctr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ctr_out == $past(ctr_in) - 64'(dec_count));

    // R7
    exit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && exit_valid |-> (VLW'(exit_idx) < $past(vl)));

    // R8
    all_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(all_mode) && !exit_valid |-> take_branch);

    // R9
    vl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(vl) == '0) |-> !exit_valid && (dec_count == '0));

endmodule

// File: tb/vbr_ctr_unit_tb.sv
// Bench for vbr_ctr_unit. A behavioural walk over the elements, in order,
// gives the expected result, which is compared after every registered update.
module vbr_ctr_unit_tb;
    localparam int N   = 8;
    localparam int VLW = $clog2(N + 1);
    localparam int CW  = $clog2(N + 1);
    localparam int IW  = $clog2(N);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] pred_mask = '0, cr_bits = '0;
    logic [VLW-1:0] vl = '0;
    logic ign_cond = 0, want_set = 0, no_ctr = 0, ctr_zero_take = 0;
    logic all_mode = 0, zero_fill = 0, fill_bit = 0, ctr_test = 0, ctr_inv = 0, mode32 = 0;
    logic [63:0] ctr_in = '0;
    logic [CW-1:0] dec_count;
    logic [63:0] ctr_out;
    logic [IW-1:0] exit_idx;
    logic exit_valid, take_branch;

    int total = 0, bad = 0, cycles = 0;

    vbr_ctr_unit #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .pred_mask(pred_mask), .cr_bits(cr_bits), .vl(vl),
        .ign_cond(ign_cond), .want_set(want_set), .no_ctr(no_ctr),
        .ctr_zero_take(ctr_zero_take), .all_mode(all_mode), .zero_fill(zero_fill),
        .fill_bit(fill_bit), .ctr_test(ctr_test), .ctr_inv(ctr_inv), .mode32(mode32),
        .ctr_in(ctr_in), .dec_count(dec_count), .ctr_out(ctr_out), .exit_idx(exit_idx),
        .exit_valid(exit_valid), .take_branch(take_branch)
    );

    always #2.5 clk = ~clk;

    // watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // behavioural walk in program order
    task automatic model(output int e_cnt, output logic [63:0] e_ctr,
                         output int e_idx, output bit e_ev, output bit e_br);
        logic [63:0] c = ctr_in;
        int lim = (int'(vl) > N) ? N : int'(vl);
        bit tb, cond, d, nz, ok;
        e_cnt = 0; e_idx = 0; e_ev = 0;
        for (int i = 0; i < lim; i++) begin
            if (!pred_mask[i] && !zero_fill) begin
                if (!no_ctr && !ctr_test && ctr_inv) begin c = c - 1; e_cnt++; end
                continue;
            end
            tb   = pred_mask[i] ? cr_bits[i] : fill_bit;
            cond = ign_cond || (tb == want_set);
            d    = !no_ctr && (!ctr_test || (ctr_inv ? !cond : cond));
            if (d) begin c = c - 1; e_cnt++; end
            nz = mode32 ? (c[31:0] != 0) : (c != 0);
            ok = no_ctr || (nz ^ ctr_zero_take);
            if (all_mode != (cond && ok)) begin e_ev = 1; e_idx = i; break; end
        end
        e_ctr = c;
        e_br  = all_mode ? !e_ev : e_ev;
    endtask

    // apply current inputs, wait for the registered result, compare
    task automatic step(input string tag);
        int e_cnt, e_idx;
        logic [63:0] e_ctr;
        bit e_ev, e_br;
        model(e_cnt, e_ctr, e_idx, e_ev, e_br);
        @(negedge clk);
        total++;
        if (int'(dec_count) != e_cnt || ctr_out !== e_ctr || int'(exit_idx) != e_idx
            || exit_valid !== e_ev || take_branch !== e_br) begin
            bad++;
            $display("FAIL %s: cnt=%0d/%0d ctr=%h/%h idx=%0d/%0d ev=%b/%b br=%b/%b", tag,
                     dec_count, e_cnt, ctr_out, e_ctr, exit_idx, e_idx,
                     exit_valid, e_ev, take_branch, e_br);
        end
    endtask

    task automatic base();
        pred_mask = '1; cr_bits = '1; vl = VLW'(N);
        ign_cond = 0; want_set = 1; no_ctr = 0; ctr_zero_take = 0;
        all_mode = 1; zero_fill = 0; fill_bit = 0; ctr_test = 0; ctr_inv = 0; mode32 = 0;
        ctr_in = 64'd100;
    endtask

    initial begin
        // R1: reset state
        ctr_in = 64'h55;
        repeat (3) @(negedge clk);
        total++;
        if (dec_count !== '0 || ctr_out !== '0 || exit_idx !== '0 || exit_valid !== 0
            || take_branch !== 0) begin
            bad++;
            $display("FAIL R1 reset: cnt=%0d ctr=%h ev=%b br=%b expected all 0",
                     dec_count, ctr_out, exit_valid, take_branch);
        end
        rst_n = 1'b1;
        base();
        step("R1 first result");
        step("R11 all pass no stop");
        all_mode = 0;                          step("R7 any-mode stop at 0");
        all_mode = 1; cr_bits = 8'b1110_1111;  step("R7 all-mode stop at 4");
        base(); pred_mask = 8'b0011_0010; cr_bits = 8'b0000_0000; want_set = 0;
        step("R2 skipped elements");
        base(); pred_mask = '0; ctr_inv = 1;   step("R4 skipped decrement");
        ctr_test = 1;                          step("R4 skipped no decrement");
        base(); pred_mask = '0; zero_fill = 1; fill_bit = 1; step("R2 fill one");
        fill_bit = 0;                          step("R2 fill zero");
        base(); cr_bits = '0; all_mode = 0; ctr_test = 1; ctr_inv = 1;
        step("R3 decrement on failure");
        ctr_inv = 0;                           step("R3 decrement on success none");
        cr_bits = 8'b1000_0000; all_mode = 1;  step("R3 success then stop");
        base(); no_ctr = 1; ctr_in = 64'd1;    step("R5 counter untouched");
        base(); ctr_in = 64'd2;                step("R6 zero crossing mid-vector");
        ctr_zero_take = 1; all_mode = 0;       step("R6 zero-take crossing");
        base(); ctr_in = 64'h1_0000_0002; mode32 = 1; step("R6 low half zero");
        mode32 = 0;                            step("R6 full width nonzero");
        base(); vl = '0;                       step("R8 vl zero all-mode");
        all_mode = 0;                          step("R8 vl zero any-mode");
        base(); vl = 4'd3;                     step("R9 vl three");
        vl = 4'd15;                            step("R9 vl above N");
        base(); ctr_in = '0; ign_cond = 1;     step("R10 wrap below zero");
        for (int k = 0; k < 500; k++) begin
            pred_mask = N'($urandom); cr_bits = N'($urandom);
            vl = VLW'($urandom_range(0, 10));
            {ign_cond, want_set, no_ctr, ctr_zero_take} = 4'($urandom);
            {all_mode, zero_fill, fill_bit, ctr_test, ctr_inv, mode32} = 6'($urandom);
            if ($urandom_range(0, 1) == 0) ctr_in = 64'($urandom_range(0, 9));
            else ctr_in = {32'($urandom_range(0, 2)), 32'($urandom_range(0, 9))};
            step("R11 mixed");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule